// File: doc/BRIEF.md
# Flash Byte-Programming Sequencer

This block sits on the host side of a byte-wide flash command port and programs a run of consecutive bytes. A single start pulse supplies a base address, a byte count and a checking policy. The bytes then arrive on a valid/ready stream. For every byte the sequencer writes the program-setup command and then the data, both to that byte's address. It then polls the status byte with separate read strobes until the ready bit comes back set.

The voltage-low and program-failure status bits are sticky in the device. The policy input selects when they are examined: after every byte, or only once after the final byte of the run. When an error is found, or when the ready bit never arrives within a bounded number of polls, no further bytes are issued. The sequencer then writes the clear-status command, writes the return-to-array command, and pulses done with an error code and the address of the byte where the check failed. A clean run ends with only the return-to-array command and a zero code.

Top module: `flash_prog_seq`

## Requirements
- R1: For each byte the sequencer writes command 40h and then the data byte, both to the same address. Addresses run upward by one from the base address, and the bytes are taken from the stream in order.
- R2: After each data write the sequencer polls status. Each poll is a read strobe high for exactly one cycle, and the strobe is never high in two consecutive cycles. The read data is sampled in the cycle after the strobe. Polling stops once bit 7 reads 1. The read and write strobes are never high together.
- R3: When the status is examined, bit 3 set gives error code 1 and bit 4 set gives error code 2. If both bits are set, code 1 is reported.
- R4: With the per-byte policy (check_each = 1), status is examined after every byte. The first failing byte ends the run, no later byte is issued, and err_addr is that byte's address.
- R5: With the deferred policy (check_each = 0), status is examined only after the last byte. Every byte is programmed, and a failure reports err_addr equal to the last byte's address.
- R6: If POLL_LIMIT consecutive polls for one byte all return bit 7 = 0, the run aborts with error code 3, and err_addr is that byte's address. This applies under either policy.
- R7: On any error the sequencer writes 50h (clear status), then FFh (array read), then asserts done. No further 40h write follows the error.
- R8: A run without error ends with one FFh write in the cycle immediately before done. Done is high for one cycle, with err_code 0 and err_addr 0.
- R9: A byte count of zero produces only the FFh write and then done with code 0. No byte is requested from the stream.
- R10: in_ready is high only while the sequencer waits for the next data byte. Low in_valid stalls the run without losing or duplicating data.
- R11: A start pulse while a run is in progress is ignored.
- R12: After reset the sequencer is idle: no strobes, busy, done, in_ready and err_code all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a run (taken only when idle) |
| check_each | input | 1 | Checking policy: 1 after every byte, 0 once at the end |
| base_addr | input | AW | Address of the first byte |
| byte_count | input | CW | Number of bytes to program |
| in_data | input | 8 | Stream data byte |
| in_valid | input | 1 | Stream byte available |
| in_ready | output | 1 | Sequencer accepts a stream byte this cycle |
| fl_addr | output | AW | Flash address |
| fl_wdata | output | 8 | Flash write data or command |
| fl_we | output | 1 | Flash write strobe, one cycle per write |
| fl_re | output | 1 | Flash read strobe, one cycle per poll |
| fl_rdata | input | 8 | Flash status byte, valid the cycle after fl_re |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err_code | output | 2 | 0 none, 1 voltage low, 2 program error, 3 poll timeout |
| err_addr | output | AW | Address of the failing byte, 0 when err_code is 0 |

## Verification
The bench sweeps both policies and byte counts from zero to four. For each byte position it injects voltage-low, program-error and both bits together, with device busy times of zero and two cycles and with gaps in the input stream. A sequencer that ignored the policy would stop early in deferred mode or run past a failure in per-byte mode, and the programmed-byte count and err_addr would expose it. A missing priority between the two status bits would report code 2 for the double fault. A skipped clear-status, or one placed after the array command, shows up in the model's command order. A read strobe held for two cycles, or a timeout counted one poll off, shows up in the model's read-strobe count against POLL_LIMIT. The bench also pulses start again in the middle of a run to confirm it changes nothing.

// File: rtl/flash_prog_pkg.sv
// Package: shared command codes, status bit positions, error codes and the
// sequencer state type for the flash byte-programming sequencer.
package flash_prog_pkg;

    localparam logic [7:0] CMD_PROG_SETUP = 8'h40;
    localparam logic [7:0] CMD_CLR_STAT   = 8'h50;
    localparam logic [7:0] CMD_ARRAY_RD   = 8'hFF;

    localparam int SR_BIT_READY = 7;
    localparam int SR_BIT_PERR  = 4;
    localparam int SR_BIT_VLOW  = 3;

    localparam logic [1:0] ERR_NONE    = 2'd0;
    localparam logic [1:0] ERR_VLOW    = 2'd1;
    localparam logic [1:0] ERR_PROG    = 2'd2;
    localparam logic [1:0] ERR_TIMEOUT = 2'd3;

    typedef enum logic [3:0] {
        S_IDLE,
        S_SETUP,
        S_DATA,
        S_READ,
        S_CHECK,
        S_CLEAR,
        S_ARRAY,
        S_FIN
    } seq_state_t;

endpackage

// File: rtl/fps_addr_track.sv
// Address tracker: holds the current byte address and the number of bytes
// still to program. Assumes load and advance are never asserted together.
module fps_addr_track #(
    parameter int AW = 17,
    parameter int CW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          advance,
    input  logic [AW-1:0] base,
    input  logic [CW-1:0] count,
    output logic [AW-1:0] addr,
    output logic          is_last
);

    logic [CW-1:0] remain;

    // Load a new run or step to the next byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr   <= '0;
            remain <= '0;
        end else if (load) begin
            addr   <= base;
            remain <= count;
        end else if (advance) begin
            addr   <= addr + AW'(1);
            remain <= remain - CW'(1);
        end
    end

    // Flag the final byte of the run.
    always_comb is_last = (remain == CW'(1));

endmodule

// File: rtl/fps_poll_timer.sv
// Poll timer: counts status polls for one byte that came back not-ready.
// expired is high on the LIMIT-th unsuccessful poll. Assumes LIMIT >= 2.
module fps_poll_timer #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic expired
);

    localparam int TW = $clog2(LIMIT);

    logic [TW-1:0] cnt;

    // Count unsuccessful polls; restart on each new byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + TW'(1);
        end
    end

    // Flag the last allowed poll.
    always_comb expired = (cnt == TW'(LIMIT - 1));

endmodule

// File: rtl/fps_status_eval.sv
// Status evaluator: decodes the device status byte into a ready flag and an
// error code, voltage-low taking priority over program failure.
module fps_status_eval
    import flash_prog_pkg::*;
(
    input  logic [7:0] status,
    output logic       ready,
    output logic [1:0] code
);

    logic unused_bits;

    // Decode ready and the prioritised error code.
    always_comb begin
        ready = status[SR_BIT_READY];
        if (status[SR_BIT_VLOW]) begin
            code = ERR_VLOW;
        end else if (status[SR_BIT_PERR]) begin
            code = ERR_PROG;
        end else begin
            code = ERR_NONE;
        end
    end

    assign unused_bits = ^{status[6:5], status[2:0]};

endmodule

// File: rtl/flash_prog_seq.sv
// Flash byte-programming sequencer (top). Issues setup and data writes per
// byte, polls status with single-cycle read strobes, checks sticky error bits
// per the latched policy, and finishes with clear-status (on error) and the
// array-read command. Assumes fl_rdata is valid the cycle after fl_re.
module flash_prog_seq
    import flash_prog_pkg::*;
#(
    parameter int AW         = 17,
    parameter int CW         = 17,
    parameter int POLL_LIMIT = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          check_each,
    input  logic [AW-1:0] base_addr,
    input  logic [CW-1:0] byte_count,
    input  logic [7:0]    in_data,
    input  logic          in_valid,
    output logic          in_ready,
    output logic [AW-1:0] fl_addr,
    output logic [7:0]    fl_wdata,
    output logic          fl_we,
    output logic          fl_re,
    input  logic [7:0]    fl_rdata,
    output logic          busy,
    output logic          done,
    output logic [1:0]    err_code,
    output logic [AW-1:0] err_addr
);

    seq_state_t    st, st_nx;
    logic          pol_each;
    logic          trk_load, trk_adv;
    logic [AW-1:0] cur_addr;
    logic          is_last;
    logic          tmr_clear, tmr_tick, tmr_expired;
    logic          sr_ready;
    logic [1:0]    sr_code;
    logic          set_err;
    logic [1:0]    new_code;
    logic [1:0]    err_q;
    logic [AW-1:0] err_addr_q;

    fps_addr_track #(.AW(AW), .CW(CW)) u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (trk_load),
        .advance (trk_adv),
        .base    (base_addr),
        .count   (byte_count),
        .addr    (cur_addr),
        .is_last (is_last)
    );

    fps_poll_timer #(.LIMIT(POLL_LIMIT)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tmr_clear),
        .tick    (tmr_tick),
        .expired (tmr_expired)
    );

    fps_status_eval u_eval (
        .status (fl_rdata),
        .ready  (sr_ready),
        .code   (sr_code)
    );

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // Latch the checking policy when a run is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_each <= 1'b0;
        end else if (st == S_IDLE && start) begin
            pol_each <= check_each;
        end
    end

    // Next-state and control decisions.
    always_comb begin
        st_nx     = st;
        trk_load  = 1'b0;
        trk_adv   = 1'b0;
        tmr_clear = 1'b0;
        tmr_tick  = 1'b0;
        set_err   = 1'b0;
        new_code  = ERR_NONE;
        case (st)
            S_IDLE: begin
                if (start) begin
                    trk_load = 1'b1;
                    st_nx    = (byte_count == '0) ? S_ARRAY : S_SETUP;
                end
            end
            S_SETUP: st_nx = S_DATA;
            S_DATA: begin
                if (in_valid) begin
                    tmr_clear = 1'b1;
                    st_nx     = S_READ;
                end
            end
            S_READ: st_nx = S_CHECK;
            S_CHECK: begin
                if (sr_ready) begin
                    if ((pol_each || is_last) && sr_code != ERR_NONE) begin
                        set_err  = 1'b1;
                        new_code = sr_code;
                        st_nx    = S_CLEAR;
                    end else if (is_last) begin
                        st_nx = S_ARRAY;
                    end else begin
                        trk_adv = 1'b1;
                        st_nx   = S_SETUP;
                    end
                end else if (tmr_expired) begin
                    set_err  = 1'b1;
                    new_code = ERR_TIMEOUT;
                    st_nx    = S_CLEAR;
                end else begin
                    tmr_tick = 1'b1;
                    st_nx    = S_READ;
                end
            end
            S_CLEAR: st_nx = S_ARRAY;
            S_ARRAY: st_nx = S_FIN;
            S_FIN:   st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    // Flash strobes, data mux and stream handshake.
    always_comb begin
        fl_we    = 1'b0;
        fl_re    = 1'b0;
        fl_wdata = 8'h00;
        in_ready = 1'b0;
        case (st)
            S_SETUP: begin
                fl_we    = 1'b1;
                fl_wdata = CMD_PROG_SETUP;
            end
            S_DATA: begin
                in_ready = 1'b1;
                fl_we    = in_valid;
                fl_wdata = in_data;
            end
            S_READ: fl_re = 1'b1;
            S_CLEAR: begin
                fl_we    = 1'b1;
                fl_wdata = CMD_CLR_STAT;
            end
            S_ARRAY: begin
                fl_we    = 1'b1;
                fl_wdata = CMD_ARRAY_RD;
            end
            default: ;
        endcase
    end

    // Error code and failing address, cleared when a run starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q      <= ERR_NONE;
            err_addr_q <= '0;
        end else if (st == S_IDLE && start) begin
            err_q      <= ERR_NONE;
            err_addr_q <= '0;
        end else if (set_err) begin
            err_q      <= new_code;
            err_addr_q <= cur_addr;
        end
    end

    assign fl_addr  = cur_addr;
    assign busy     = (st != S_IDLE);
    assign done     = (st == S_FIN);
    assign err_code = err_q;
    assign err_addr = err_addr_q;

endmodule

// File: rtl/fps_checker.sv
// Checker: temporal properties on the sequencer's flash and stream ports.
// Attached to every flash_prog_seq instance by the bind below.
module fps_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       fl_we,
    input logic       fl_re,
    input logic [7:0] fl_wdata,
    input logic       in_ready,
    input logic       busy,
    input logic       done,
    input logic [1:0] err_code
);

    assert_strobe_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_we && fl_re));

    assert_fresh_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fl_re |=> !fl_re);

    assert_array_before_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(fl_we) && $past(fl_wdata) == 8'hFF));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_clear_on_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_code != 2'd0) |-> ($past(fl_we, 2) && $past(fl_wdata, 2) == 8'h50));

    assert_ready_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (busy && !fl_re));

endmodule

bind flash_prog_seq fps_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fl_we    (fl_we),
    .fl_re    (fl_re),
    .fl_wdata (fl_wdata),
    .in_ready (in_ready),
    .busy     (busy),
    .done     (done),
    .err_code (err_code)
);

// File: tb/flash_prog_seq_tb.sv
module flash_prog_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int CW = 4;
    localparam int PL = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          check_each = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [CW-1:0] byte_count = '0;
    logic [7:0]    in_data = 8'h00;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [AW-1:0] fl_addr;
    logic [7:0]    fl_wdata;
    logic          fl_we, fl_re;
    logic [7:0]    fl_rdata;
    logic          busy, done;
    logic [1:0]    err_code;
    logic [AW-1:0] err_addr;

    int checks = 0;
    int errors = 0;

    // model controls
    logic          m_clr = 1'b0;
    int            m_lat = 0;
    logic          m_inj_en = 1'b0;
    logic [AW-1:0] m_inj_addr = '0;
    logic [1:0]    m_inj_bits = 2'b00;
    logic          m_hang_en = 1'b0;
    logic [AW-1:0] m_hang_addr = '0;
    logic [AW-1:0] cur_base = '0;
    int            cur_seed = 0;
    logic          gap_mode = 1'b0;

    // model state and statistics
    logic [7:0] rdata_q = 8'h00;
    int  busy_cnt = 0;
    bit  hung = 0, armed = 0, vlow = 0, perr = 0, ff_seen = 0, prev_re = 0;
    int  prog_cnt = 0, setup_cnt = 0, clr_cnt = 0, ff_cnt = 0;
    int  data_bad = 0, order_bad = 0, re_viol = 0, re_since_prog = 0;
    int  src_idx = 0;

    assign fl_rdata = rdata_q;

    flash_prog_seq #(.AW(AW), .CW(CW), .POLL_LIMIT(PL)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .check_each(check_each),
        .base_addr(base_addr), .byte_count(byte_count),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
        .fl_rdata(fl_rdata), .busy(busy), .done(done),
        .err_code(err_code), .err_addr(err_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] byte_of(input int idx, input int seed);
        return 8'((idx * 29 + seed * 7 + 3) & 255);
    endfunction

    // behavioural flash device with sticky status and a command log
    always @(posedge clk) begin
        if (m_clr) begin
            busy_cnt = 0; hung = 0; armed = 0; vlow = 0; perr = 0; ff_seen = 0;
            prog_cnt = 0; setup_cnt = 0; clr_cnt = 0; ff_cnt = 0;
            data_bad = 0; order_bad = 0; re_viol = 0; re_since_prog = 0;
            src_idx = 0; prev_re = 0;
        end else begin
            if (in_valid && in_ready) src_idx = src_idx + 1;
            if (fl_re && prev_re) re_viol = re_viol + 1;
            prev_re = fl_re;
            if (fl_re) begin
                re_since_prog = re_since_prog + 1;
                rdata_q <= {(busy_cnt == 0 && !hung), 2'b00, perr, vlow, 3'b000};
            end
            if (fl_we) begin
                if (ff_seen) order_bad = order_bad + 1;
                if (armed) begin
                    if (fl_addr != AW'(cur_base + AW'(prog_cnt))) data_bad = data_bad + 1;
                    if (fl_wdata != byte_of(prog_cnt, cur_seed)) data_bad = data_bad + 1;
                    if (m_inj_en && fl_addr == m_inj_addr) begin
                        vlow = vlow | m_inj_bits[0];
                        perr = perr | m_inj_bits[1];
                    end
                    if (m_hang_en && fl_addr == m_hang_addr) hung = 1;
                    prog_cnt = prog_cnt + 1;
                    re_since_prog = 0;
                    busy_cnt = m_lat;
                    armed = 0;
                end else if (fl_wdata == 8'h40) begin
                    if (fl_addr != AW'(cur_base + AW'(setup_cnt))) data_bad = data_bad + 1;
                    setup_cnt = setup_cnt + 1;
                    armed = 1;
                end else if (fl_wdata == 8'h50) begin
                    clr_cnt = clr_cnt + 1;
                    vlow = 0; perr = 0;
                end else if (fl_wdata == 8'hFF) begin
                    ff_cnt = ff_cnt + 1;
                    ff_seen = 1;
                end else begin
                    order_bad = order_bad + 1;
                end
            end else if (busy_cnt > 0) begin
                busy_cnt = busy_cnt - 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // run one programming job and check the results against the requirements
    task automatic run_case(input bit pol, input int cnt, input int base, input int lat,
                            input bit gap, input int em, input int k,
                            input bit hang, input bit restart, input int seed);
        int exp_code, exp_addr, exp_prog, exp_clr, waited;
        bit got;
        @(negedge clk);
        m_clr      = 1'b1;
        m_lat      = lat;
        gap_mode   = gap;
        cur_base   = AW'(base);
        cur_seed   = seed;
        m_inj_en   = (em != 0);
        m_inj_addr = AW'(base + k);
        m_inj_bits = (em == 1) ? 2'b01 : (em == 2) ? 2'b10 : 2'b11;
        m_hang_en  = hang;
        m_hang_addr = AW'(base + k);
        @(negedge clk);
        m_clr = 1'b0;
        start = 1'b1; check_each = pol; base_addr = AW'(base); byte_count = CW'(cnt);
        @(negedge clk);
        start = 1'b0;
        if (restart) begin
            repeat (3) @(negedge clk);
            start = 1'b1; byte_count = CW'(cnt + 2); base_addr = AW'(base + 9); check_each = !pol;
            @(negedge clk);
            start = 1'b0;
        end
        got = 0; waited = 0;
        while (!got && waited < 3000) begin
            if (done) got = 1;
            else begin @(negedge clk); waited = waited + 1; end
        end
        chk(got, "R8 done reached", int'(got), 1);
        // expectations
        if (hang) begin
            exp_code = 3; exp_addr = (base + k) & 255; exp_prog = k + 1; exp_clr = 1;
        end else if (em != 0 && pol) begin
            exp_code = (em == 2) ? 2 : 1; exp_addr = (base + k) & 255; exp_prog = k + 1; exp_clr = 1;
        end else if (em != 0) begin
            exp_code = (em == 2) ? 2 : 1; exp_addr = (base + cnt - 1) & 255; exp_prog = cnt; exp_clr = 1;
        end else begin
            exp_code = 0; exp_addr = 0; exp_prog = cnt; exp_clr = 0;
        end
        if (hang) begin
            chk(err_code == 2'(exp_code), "R6 timeout code", int'(err_code), exp_code);
            chk(re_since_prog == PL, "R6 polls before timeout", re_since_prog, PL);
        end else if (pol) begin
            chk(err_code == 2'(exp_code), "R4 R3 error code", int'(err_code), exp_code);
        end else begin
            chk(err_code == 2'(exp_code), "R5 R3 error code", int'(err_code), exp_code);
        end
        chk(err_addr == AW'(exp_addr), pol ? "R4 err_addr" : "R5 err_addr", int'(err_addr), exp_addr);
        chk(prog_cnt == exp_prog, cnt == 0 ? "R9 bytes programmed" : "R4 R5 bytes programmed",
            prog_cnt, exp_prog);
        chk(setup_cnt == exp_prog, "R1 setup count", setup_cnt, exp_prog);
        chk(data_bad == 0, "R1 R10 address and data sequence", data_bad, 0);
        chk(src_idx == exp_prog, "R10 stream bytes consumed", src_idx, exp_prog);
        chk(clr_cnt == exp_clr, "R7 clear-status writes", clr_cnt, exp_clr);
        chk(ff_cnt == 1 && order_bad == 0, "R8 R7 single final array write", ff_cnt * 100 + order_bad, 100);
        chk(re_viol == 0, "R2 fresh read strobes", re_viol, 0);
        if (restart) chk(err_code == 2'(exp_code), "R11 restart ignored", int'(err_code), exp_code);
        @(negedge clk);
        chk(!done && !busy, "R8 done single cycle", int'(done), 0);
    endtask

    // stream driver: valid with optional gaps, data from the accepted index
    initial begin
        int cyc;
        cyc = 0;
        forever begin
            @(negedge clk);
            cyc = cyc + 1;
            in_valid = gap_mode ? ((cyc % 3) != 1) : 1'b1;
            in_data  = byte_of(src_idx, cur_seed);
        end
    end

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        errors = errors + 1;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int run;
        run = 0;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(!fl_we && !fl_re && !busy && !done && !in_ready && err_code == 2'd0,
            "R12 reset idle", int'({fl_we, fl_re, busy, done, in_ready}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!fl_we && !fl_re && !busy && err_code == 2'd0, "R12 idle after reset",
            int'({fl_we, fl_re, busy}), 0);
        // main sweep: policy, count, latency, gaps, error kind and position
        for (int pol = 0; pol < 2; pol++) begin
            for (int cnt = 0; cnt <= 4; cnt++) begin
                for (int lat = 0; lat <= 2; lat += 2) begin
                    for (int gap = 0; gap < 2; gap++) begin
                        for (int em = 0; em < 4; em++) begin
                            for (int k = 0; k < ((em == 0) ? 1 : cnt); k++) begin
                                run = run + 1;
                                run_case(pol[0], cnt, (run * 11) & 255, lat, gap[0], em, k,
                                         1'b0, 1'b0, run);
                            end
                        end
                    end
                end
            end
        end
        // R6 poll timeout under both policies
        for (int pol = 0; pol < 2; pol++) begin
            for (int cnt = 1; cnt <= 3; cnt++) begin
                for (int k = 0; k < cnt; k++) begin
                    run = run + 1;
                    run_case(pol[0], cnt, (run * 13) & 255, 1, 1'b0, 0, k, 1'b1, 1'b0, run);
                end
            end
        end
        // R11 start while busy, with and without an error
        run_case(1'b1, 3, 40, 2, 1'b1, 0, 0, 1'b0, 1'b1, 901);
        run_case(1'b0, 3, 80, 1, 1'b0, 2, 1, 1'b0, 1'b1, 902);
        run_case(1'b1, 4, 250, 0, 1'b0, 3, 2, 1'b0, 1'b1, 903);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule